// File: doc/BRIEF.md
# Clock-Compensating Elastic Buffer for 10-bit Line Symbols

This block is a dual-clock FIFO that sits between a serial receiver and the rest of the chip. Symbols are written on the clock recovered from the incoming line and read on the local clock. Both clocks are nominally equal, but they may differ by a few hundred ppm. Each side keeps its own binary pointer and sends a Gray-coded copy through a two-flop synchronizer into the other clock domain. Each side then computes the fill level from its own pointer and the synchronized copy.

In stream mode the buffer keeps its fill level near half depth by changing the idle parts of the stream. An idle region starts with a marker symbol and continues as long as fill symbols follow it. When the write side sees the buffer running high, it drops one fill symbol of the region. When the read side sees it running low, it repeats one fill symbol of the region. Each region is changed at most once. Payload symbols, and fill symbols that do not follow a marker, are never changed. In packet mode no symbol is ever added or removed. Instead, reading waits at each packet start until the buffer holds half its depth, and it stops without error once the packet has drained.

Overflow and underflow are recorded in sticky flags, one in each clock domain. Reset clears them.

Top module: `elastic_symbol_buffer`

## Requirements
- R1: After reset, `rd_valid`, `ovf_err` and `unf_err` are 0.
- R2: Write and read pointers cross between the clock domains as Gray codes. With no overflow, the read stream holds every non-fill symbol that was written, in order, each exactly once.
- R3: Reading starts only once the read-side level reaches NOMINAL (half of 2^AW). Before that, `rd_valid` stays 0 in both modes.
- R4: In stream mode, suppose a fill symbol (FILL_SYM) arrives inside a region while the write-side level exceeds NOMINAL+MARGIN. A region is a run of FILL_SYM symbols directly after a MARK_SYM symbol. That fill symbol is then not stored, so the region loses one fill symbol.
- R5: In stream mode, suppose the read side is about to deliver a fill symbol inside a region while the read-side level is below NOMINAL-MARGIN. That fill symbol is then delivered twice.
- R6: A region gains or loses at most one fill symbol. When the level stays between the two thresholds, no region is changed.
- R7: Payload symbols are never removed or repeated. The same holds for MARK_SYM and for FILL_SYM symbols that do not directly follow a marker or another fill symbol of the same region.
- R8: In packet mode (`pkt_mode`=1), the read stream equals the write stream exactly. Reading stops with `rd_valid`=0 when the buffer drains, and draining does not set `unf_err`.
- R9: A symbol offered while the write-side level shows full (2^AW) is not stored and sets `ovf_err`. Symbols already stored are unaffected, and the flag holds until reset.
- R10: In stream mode, a read request while reading is running and the read-side level is 0 sets `unf_err` and yields no valid symbol. The flag holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered line clock (write side) |
| wrst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_en | input | 1 | A symbol is offered this write cycle |
| wr_sym | input | SYM_W | Offered symbol |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| rclk | input | 1 | Local clock (read side) |
| rrst_n | input | 1 | Active-low asynchronous reset, read side |
| rd_en | input | 1 | Consumer requests one symbol this read cycle |
| rd_sym | output | SYM_W | Delivered symbol |
| rd_valid | output | 1 | `rd_sym` holds a delivered symbol |
| unf_err | output | 1 | Sticky underflow flag (read domain) |
| pkt_mode | input | 1 | 1: packet mode, 0: stream mode; change only in reset |

## Verification
The bench builds the block with AW=5 (32 entries, NOMINAL 16) and MARGIN=8. With the pointer-synchronizer lag included, a balanced stream settles near a write-side level of 20 and a read-side level of 17. That is inside both thresholds, so the no-change case is observable. Pausing the reader for eight cycles pushes the write-side level above 24, and pausing the writer for fourteen cycles pulls the read-side level below 8. Each pause can be reached in a few dozen cycles, and the resulting fill changes are checked region by region against the written stream. The same depth lets the bench fill the buffer completely within 40 writes and drain it to empty to reach both error flags.

// File: rtl/elastic_symbol_buffer.sv
module elastic_symbol_buffer #(
  parameter int SYM_W = 10,
  parameter int AW = 5,
  parameter int MARGIN = 8,
  parameter logic [SYM_W-1:0] MARK_SYM = 10'h305,
  parameter logic [SYM_W-1:0] FILL_SYM = 10'h0FA
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_sym,
  output logic             ovf_err,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en,
  output logic [SYM_W-1:0] rd_sym,
  output logic             rd_valid,
  output logic             unf_err,
  input  logic             pkt_mode
);
  localparam int DEPTH = 1 << AW;
  localparam int NOMINAL = DEPTH / 2;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);
  localparam logic [PW-1:0] HI_L = PW'(NOMINAL + MARGIN);
  localparam logic [PW-1:0] LO_L = PW'(NOMINAL - MARGIN);
  localparam logic [PW-1:0] NOM_L = PW'(NOMINAL);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [SYM_W-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, wlevel;
  logic w_reg, w_done, w_is_fill, w_is_mark, w_drop, w_full, w_push;

  assign wlevel    = wbin - g2b(rg_s2);
  assign w_is_fill = (wr_sym == FILL_SYM);
  assign w_is_mark = (wr_sym == MARK_SYM);
  assign w_drop    = wr_en && !pkt_mode && w_reg && w_is_fill && !w_done && (wlevel > HI_L);
  assign w_full    = (wlevel == FULL_L);
  assign w_push    = wr_en && !w_drop && !w_full;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      w_reg <= 1'b0;
      w_done <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (w_push) begin
        wbin <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (wr_en && w_full && !w_drop) ovf_err <= 1'b1;
      if (wr_en) begin
        if (w_is_mark) begin
          w_reg <= 1'b1;
          w_done <= 1'b0;
        end else if (!w_is_fill) begin
          w_reg <= 1'b0;
        end
      end
      if (w_drop) w_done <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (w_push) mem[wbin[AW-1:0]] <= wr_sym;
  end

  // read domain
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rlevel;
  logic running, r_reg, r_done, r_empty, r_take, r_hold;
  logic [SYM_W-1:0] head;

  assign rlevel  = g2b(wg_s2) - rbin;
  assign head    = mem[rbin[AW-1:0]];
  assign r_empty = (rlevel == '0);
  assign r_take  = rd_en && running && !r_empty;
  assign r_hold  = r_take && !pkt_mode && r_reg && (head == FILL_SYM) && !r_done && (rlevel < LO_L);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      running <= 1'b0;
      r_reg <= 1'b0;
      r_done <= 1'b0;
      rd_sym <= '0;
      rd_valid <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rd_valid <= r_take;
      if (r_take) rd_sym <= head;
      if (r_take && !r_hold) begin
        rbin <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end
      if (r_take) begin
        if (head == MARK_SYM) begin
          r_reg <= 1'b1;
          r_done <= 1'b0;
        end else if (head != FILL_SYM) begin
          r_reg <= 1'b0;
        end
      end
      if (r_hold) r_done <= 1'b1;
      if (!running && rlevel >= NOM_L) running <= 1'b1;
      else if (running && pkt_mode && r_empty) running <= 1'b0;
      if (rd_en && running && r_empty && !pkt_mode) unf_err <= 1'b1;
    end
  end

  AST_GRAY_W: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_GRAY_R: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
  AST_NO_READ_IDLE: assert property (@(posedge rclk) disable iff (!rrst_n)
    !running |=> !rd_valid); // R3
  AST_ONE_DROP: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_drop |=> !w_drop); // R6
  AST_PKT_NO_UNF: assert property (@(posedge rclk) disable iff (!rrst_n)
    (pkt_mode && rd_en && r_empty) |=> (unf_err == $past(unf_err))); // R8
  AST_LEVEL_BOUND: assert property (@(posedge wclk) disable iff (!wrst_n)
    wlevel <= FULL_L); // R9
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
    ovf_err |=> ovf_err); // R9
  AST_UNF_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    unf_err |=> unf_err); // R10
  AST_UNF_NO_DATA: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && running && r_empty) |=> !rd_valid); // R10
endmodule

// File: tb/elastic_symbol_buffer_tb.sv
`timescale 1ns/1ps
module elastic_symbol_buffer_tb_top;
  localparam logic [9:0] MARK = 10'h305;
  localparam logic [9:0] FILL = 10'h0FA;
  localparam int NOM = 16;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, pkt_mode = 0;
  logic [9:0] wr_sym = '0;
  logic [9:0] rd_sym;
  logic rd_valid, ovf_err, unf_err;

  always #2.5 wclk = ~wclk;
  initial begin
    #1.7;
    forever #2.5 rclk = ~rclk;
  end

  elastic_symbol_buffer #(.SYM_W(10), .AW(5), .MARGIN(8), .MARK_SYM(MARK), .FILL_SYM(FILL)) dut_i (
    .wclk(wclk), .wrst_n(rst_n), .wr_en(wr_en), .wr_sym(wr_sym), .ovf_err(ovf_err),
    .rclk(rclk), .rrst_n(rst_n), .rd_en(rd_en), .rd_sym(rd_sym), .rd_valid(rd_valid),
    .unf_err(unf_err), .pkt_mode(pkt_mode));

  logic [9:0] in_q[$];
  logic [9:0] out_q[$];
  int total = 0, fails = 0, wr_count = 0, wr_at_first = -1, pcnt = 0;
  bit seen = 0, done = 0;

  always @(negedge rclk) begin
    if (rd_valid) begin
      out_q.push_back(rd_sym);
      if (!seen) begin
        seen = 1;
        wr_at_first = wr_count;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit pm);
    rst_n = 0; wr_en = 0; rd_en = 0; pkt_mode = pm;
    repeat (3) @(negedge wclk);
    in_q.delete(); out_q.delete();
    seen = 0; wr_count = 0; wr_at_first = -1;
    rst_n = 1;
    @(negedge wclk);
  endtask

  task automatic send(input logic [9:0] s);
    @(negedge wclk);
    wr_en = 1; wr_sym = s;
    in_q.push_back(s);
    wr_count++;
  endtask

  task automatic idle_w(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge wclk);
      wr_en = 0;
    end
  endtask

  task automatic payload(input int n);
    for (int k = 0; k < n; k++) begin
      send({2'b01, 8'(pcnt)});
      pcnt++;
    end
  endtask

  task automatic blocks(input int n);
    for (int b = 0; b < n; b++) begin
      payload(4);
      send(MARK);
      send(FILL); send(FILL); send(FILL);
      payload(1);
      send(FILL);
      payload(1);
    end
  endtask

  task automatic analyze(output int ins, output int del, output int bad);
    int i, j, ci, co;
    bit rg;
    i = 0; j = 0; ins = 0; del = 0; bad = 0;
    while (i < in_q.size() && j < out_q.size()) begin
      if (in_q[i] == FILL) begin
        rg = (i > 0) && (in_q[i-1] == MARK);
        ci = 0; co = 0;
        while (i < in_q.size() && in_q[i] == FILL) begin ci++; i++; end
        while (j < out_q.size() && out_q[j] == FILL) begin co++; j++; end
        if (i >= in_q.size() || j >= out_q.size()) break;
        if (rg && co == ci + 1) ins++;
        else if (rg && co + 1 == ci) del++;
        else if (co != ci) bad++;
      end else begin
        if (out_q[j] != in_q[i]) bad++;
        i++; j++;
      end
    end
  endtask

  int ins, del, bad;

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // reset state
    do_reset(0);
    repeat (4) @(negedge rclk);
    check(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
    check(ovf_err == 0, "R1", "ovf_err after reset", ovf_err, 0);
    check(unf_err == 0, "R1", "unf_err after reset", unf_err, 0);

    // balanced stream
    do_reset(0);
    rd_en = 1;
    blocks(20);
    @(negedge rclk); rd_en = 0;
    repeat (4) @(negedge rclk);
    analyze(ins, del, bad);
    check(bad == 0, "R2", "balanced stream mismatches", bad, 0);
    check(ins == 0 && del == 0, "R6", "balanced region changes", ins + del, 0);
    check(wr_at_first >= NOM, "R3", "writes before first read (stream)", wr_at_first, NOM);
    check(out_q.size() > 150, "R2", "symbols delivered", out_q.size(), 151);
    check(ovf_err == 0 && unf_err == 0, "R2", "errors in balanced stream", ovf_err + unf_err, 0);

    // high level: deletion
    do_reset(0);
    rd_en = 1;
    fork
      begin payload(60); blocks(10); end
      begin
        while (out_q.size() < 20) @(negedge rclk);
        rd_en = 0;
        repeat (8) @(negedge rclk);
        rd_en = 1;
      end
    join
    @(negedge rclk); rd_en = 0;
    repeat (4) @(negedge rclk);
    analyze(ins, del, bad);
    check(del >= 1, "R4", "regions shortened", del, 1);
    check(ins == 0, "R6", "insertions at high level", ins, 0);
    check(bad == 0, "R7", "payload/outside fill changes at high level", bad, 0);
    check(ovf_err == 0, "R4", "ovf_err at high level", ovf_err, 0);

    // low level: insertion
    do_reset(0);
    rd_en = 1;
    payload(60);
    idle_w(14);
    blocks(10);
    @(negedge rclk); rd_en = 0;
    repeat (4) @(negedge rclk);
    analyze(ins, del, bad);
    check(ins >= 1, "R5", "regions lengthened", ins, 1);
    check(del == 0, "R6", "deletions at low level", del, 0);
    check(bad == 0, "R7", "payload/outside fill changes at low level", bad, 0);
    check(unf_err == 0, "R10", "unf_err at low level", unf_err, 0);

    // packet mode
    do_reset(1);
    rd_en = 1;
    for (int k = 0; k < 40; k++) begin
      if (k % 8 == 7) idle_w(1);
      if (k % 10 == 5) send(MARK);
      else if (k % 10 > 5 && k % 10 < 9) send(FILL);
      else payload(1);
    end
    idle_w(1);
    check(wr_at_first >= NOM, "R3", "writes before first read (packet)", wr_at_first, NOM);
    repeat (40) @(negedge rclk);
    check(out_q.size() == 40, "R8", "packet 1 symbols out", out_q.size(), 40);
    check(rd_valid == 0, "R8", "rd_valid after drain", rd_valid, 0);
    check(unf_err == 0, "R8", "unf_err after drain", unf_err, 0);
    seen = 0; wr_count = 0;
    payload(24);
    idle_w(1);
    repeat (50) @(negedge rclk);
    check(wr_at_first >= NOM, "R3", "writes before packet 2 read", wr_at_first, NOM);
    check(out_q.size() == 64, "R8", "total packet symbols out", out_q.size(), 64);
    bad = 0;
    for (int k = 0; k < 64 && k < out_q.size(); k++) if (out_q[k] != in_q[k]) bad++;
    check(bad == 0, "R8", "packet mode exact stream mismatches", bad, 0);
    check(unf_err == 0, "R8", "unf_err after packet 2", unf_err, 0);

    // overflow then underflow
    do_reset(0);
    payload(40);
    idle_w(1);
    check(ovf_err == 1, "R9", "ovf_err after 40 writes", ovf_err, 1);
    idle_w(10);
    check(ovf_err == 1, "R9", "ovf_err sticky", ovf_err, 1);
    rd_en = 1;
    repeat (50) @(negedge rclk);
    check(out_q.size() == 32, "R9", "stored symbols delivered", out_q.size(), 32);
    bad = 0;
    for (int k = 0; k < 32 && k < out_q.size(); k++) if (out_q[k] != in_q[k]) bad++;
    check(bad == 0, "R9", "stored symbols mismatches", bad, 0);
    check(unf_err == 1, "R10", "unf_err after drain in stream mode", unf_err, 1);
    check(rd_valid == 0, "R10", "rd_valid while empty", rd_valid, 0);
    payload(5);
    idle_w(1);
    repeat (10) @(negedge rclk);
    check(unf_err == 1, "R10", "unf_err sticky", unf_err, 1);
    do_reset(0);
    check(ovf_err == 0 && unf_err == 0, "R1", "flags cleared by reset", ovf_err + unf_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule